// File: doc/BRIEF.md
# Typed-Flit Synchronous Link Framer

This block is the two ends of a short, wide link between neighbouring switch ports that run on one shared clock. One flit, which is also one phit, crosses the link each cycle. A flit has a 16-bit data field and a 4-bit control field. Two of the control bits give the flit its kind: idle, routing tag, body or end-of-packet. Packet boundaries are therefore carried beside the data and never inside it.

The transmitter takes a word stream with a last marker. The first word of each packet is the routing tag. It labels every accepted word with a flit kind and registers the result onto the forward link. The transmitter keeps a credit count for the receiver's buffer. It accepts a word only while that count is above zero, and it puts idle flits on the link in every cycle with no accepted word.

The receiver checks the order of the flits and rebuilds the packets in a small buffer. It returns credits on four reverse wires as a count per cycle. It raises an error pulse on an out-of-order flit and drops flits until the next routing tag. The forward and reverse wires are separate ports, so the two ends can be wired back to back or driven apart.

Top module: `flit_link`

## Requirements
- R1: The forward control field uses bits [1:0] for the flit kind: 00 idle, 01 routing tag, 10 body, 11 end-of-packet. Bits [3:2] are always driven to 0.
- R2: The first word accepted for a packet goes out as a tag. Each later word goes out as a body flit, except the word with `in_last`, which goes out as an end flit. A packet with one data word therefore goes out as a tag followed directly by an end flit. A flit appears on `link_ctl`/`link_data` in the cycle after its handshake. `in_last` on the tag word is ignored, so every packet has at least one data word.
- R3: The credit count resets to DEPTH. `in_ready` is high exactly while the count is non-zero. Each accepted word uses one credit. In a cycle with no handshake, the next flit is idle.
- R4: The value on `credit_in` (0 to 15) is added to the credit count at every clock edge. `in_ready` can therefore rise in the cycle after a credit arrives.
- R5: The receiver keeps accepted tag, body and end flits in a DEPTH-entry buffer, in arrival order. An accepted flit is visible on the output one cycle after it arrives. `out_first` marks a tag and `out_last` marks an end. The output holds its value while `out_ready` is low.
- R6: In the next cycle, `credit_ret` carries the count of buffer pops plus discarded non-idle flits from this cycle.
- R7: `proto_err` pulses one cycle after either of two flits: a body or end flit that arrives with no packet open (outside the drop state), or a tag flit that arrives while a packet is open. The offending flit is discarded.
- R8: After an error, body and end flits are discarded without raising a further error until a tag arrives. That tag opens a new packet normally.
- R9: The receiver ignores control bits [3:2]. Idle flits store nothing and return no credit.
- R10: With the credit rule in place, the receive buffer is never written while it is full.
- R11: When the two ends are wired back to back, the output sequence of words, with their first and last marks, equals the input sequence under any pattern of stalls at either end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source word valid |
| in_data | input | DW | Source word (the first word of a packet is the routing tag) |
| in_last | input | 1 | Marks the last word of a packet |
| in_ready | output | 1 | Transmitter holds a credit and accepts the word |
| link_data | output | DW | Forward flit data |
| link_ctl | output | 4 | Forward control: [1:0] flit kind, [3:2] zero |
| credit_in | input | 4 | Credits returned from the far receiver |
| rx_data | input | DW | Received flit data |
| rx_ctl | input | 4 | Received control field |
| credit_ret | output | 4 | Credits sent back toward the transmitter |
| out_valid | output | 1 | Buffered word available |
| out_data | output | DW | Buffered word |
| out_first | output | 1 | Word is a routing tag |
| out_last | output | 1 | Word ended its packet |
| out_ready | input | 1 | Consumer takes the word |
| proto_err | output | 1 | Framing error pulse |

## Verification
A flit is due on the forward link one edge after its source handshake. The bench checks it 1 ns after that edge. A received flit shows on the buffer output one edge after it reaches `rx_ctl`. A pop or a drop shows on `credit_ret` one edge later, and `in_ready` recovers one edge after that. The directed credit test samples at each of those falling edges in turn. `proto_err` is due one edge after the offending flit. The injection tests therefore drive a flit on one falling edge and read every receiver result at the next.

// File: rtl/flit_link.sv
module flit_link #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic [DW-1:0] link_data,
  output logic [3:0]    link_ctl,
  input  logic [3:0]    credit_in,
  input  logic [DW-1:0] rx_data,
  input  logic [3:0]    rx_ctl,
  output logic [3:0]    credit_ret,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_first,
  output logic          out_last,
  input  logic          out_ready,
  output logic          proto_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);
  localparam int CW = $clog2(DEPTH + 16) + 1;
  localparam logic [1:0] K_IDLE = 2'b00, K_TAG = 2'b01, K_BODY = 2'b10, K_END = 2'b11;

  // transmit side
  logic [CW-1:0] credits;
  logic          tx_mid;
  logic          tx_fire;
  logic [1:0]    tx_kind;

  assign in_ready = (credits != '0);
  assign tx_fire  = in_valid & in_ready;
  assign tx_kind  = !tx_mid ? K_TAG : (in_last ? K_END : K_BODY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credits   <= CW'(DEPTH);
      tx_mid    <= 1'b0;
      link_data <= '0;
      link_ctl  <= '0;
    end else begin
      credits   <= credits - CW'(tx_fire) + CW'(credit_in);
      link_ctl  <= {2'b00, tx_fire ? tx_kind : K_IDLE};
      link_data <= tx_fire ? in_data : '0;
      if (tx_fire) tx_mid <= !tx_mid ? 1'b1 : !in_last;
    end
  end

  // R3
  idle_when_no_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    credits == '0 |=> link_ctl[1:0] == K_IDLE);

  // receive side
  logic [1:0] rx_kind;
  logic       rx_open, rx_skip;
  logic       is_tag, is_data, bad, accept, drop;

  assign rx_kind = rx_ctl[1:0];
  assign is_tag  = (rx_kind == K_TAG);
  assign is_data = (rx_kind == K_BODY) | (rx_kind == K_END);
  assign bad     = (is_tag & rx_open) | (is_data & !rx_open & !rx_skip);
  assign accept  = (is_tag & !rx_open) | (is_data & rx_open);
  assign drop    = (is_tag | is_data) & !accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_open   <= 1'b0;
      rx_skip   <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      proto_err <= bad;
      if (bad) begin
        rx_open <= 1'b0;
        rx_skip <= 1'b1;
      end else if (accept && is_tag) begin
        rx_open <= 1'b1;
        rx_skip <= 1'b0;
      end else if (accept && rx_kind == K_END) begin
        rx_open <= 1'b0;
      end
    end
  end

  // R8
  single_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> !proto_err);

  // receive buffer
  logic [DW+1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [NW-1:0] cnt;
  logic          wr, rd;

  assign wr        = accept;
  assign out_valid = (cnt != '0);
  assign rd        = out_valid & out_ready;
  assign {out_first, out_last, out_data} = mem[rptr];

  always_ff @(posedge clk)
    if (wr) mem[wptr] <= {is_tag, rx_kind == K_END, rx_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr       <= '0;
      rptr       <= '0;
      cnt        <= '0;
      credit_ret <= '0;
    end else begin
      if (wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      cnt        <= cnt + NW'(wr) - NW'(rd);
      credit_ret <= {3'b000, rd} + {3'b000, drop};
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> cnt != NW'(DEPTH));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R6
  credit_ret_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    credit_ret <= 4'd2);
endmodule

// File: tb/flit_link_bench.sv
module flit_link_bench;
  localparam int DW = 16;
  localparam int DEPTH = 4;
  localparam int NPKT = 8;
  localparam int PKT_LEN [NPKT]  = '{1, 3, 1, 6, 2, 9, 1, 4};
  localparam int PKT_STALL [NPKT] = '{0, 50, 80, 0, 30, 70, 10, 90};

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [DW-1:0] in_data = '0, link_data, rx_data, out_data;
  logic [3:0] link_ctl, rx_ctl, credit_in, credit_ret;
  logic out_valid, out_first, out_last, proto_err;
  logic out_ready = 1'b0;
  logic inj = 1'b0;
  logic [DW-1:0] inj_data = '0;
  logic [3:0] inj_ctl = '0;
  logic sink_en = 1'b0;
  int stall_pct = 0;
  int tests = 0, fails = 0;
  logic [DW+1:0] exp_q [$];

  always #5 clk = ~clk;

  assign rx_data   = inj ? inj_data : link_data;
  assign rx_ctl    = inj ? inj_ctl  : link_ctl;
  assign credit_in = inj ? 4'd0     : credit_ret;

  flit_link #(.DW(DW), .DEPTH(DEPTH)) u_flit_link (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .link_data(link_data), .link_ctl(link_ctl), .credit_in(credit_in),
    .rx_data(rx_data), .rx_ctl(rx_ctl), .credit_ret(credit_ret), .out_valid(out_valid),
    .out_data(out_data), .out_first(out_first), .out_last(out_last), .out_ready(out_ready),
    .proto_err(proto_err));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic send_pkt(input int n, input int id);
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = DW'((id << 8) + i);
      in_last  = (i == n);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      exp_q.push_back({i == 0, i == n, in_data});
      #1;
      // R1 R2: flit kind on the link one edge after handshake
      chk("R2", {28'd0, link_ctl}, {30'd0, (i == 0) ? 2'b01 : (i == n) ? 2'b11 : 2'b10});
      chk("R1", {16'd0, link_data}, {16'd0, in_data});
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic put(input logic [3:0] c, input logic [DW-1:0] d);
    @(negedge clk);
    inj_ctl  = c;
    inj_data = d;
  endtask

  // sink: choose ready, then compare the word taken at the coming edge (R11)
  initial forever begin
    @(negedge clk);
    if (sink_en) begin
      out_ready = (($urandom % 100) >= 32'(stall_pct));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk("R11", {14'd0, out_first, out_last, out_data}, 32'hFFFF_FFFF);
        else chk("R11", {14'd0, out_first, out_last, out_data}, {14'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state R3 R5 R6 R7
    chk("R3", {31'd0, in_ready}, 32'd1);
    chk("R5", {31'd0, out_valid}, 32'd0);
    chk("R1", {28'd0, link_ctl}, 32'd0);
    chk("R6", {28'd0, credit_ret}, 32'd0);
    chk("R7", {31'd0, proto_err}, 32'd0);

    // table of packets with sink stall rates (R2 R5 R11)
    sink_en = 1'b1;
    for (int p = 0; p < NPKT; p++) begin
      stall_pct = PKT_STALL[p];
      send_pkt(PKT_LEN[p], p);
    end
    stall_pct = 0;
    repeat (20) @(negedge clk);
    chk("R11", exp_q.size(), 32'd0);

    // random packet lengths with random stalls and source gaps (R10 R11)
    for (int p = 0; p < 40; p++) begin
      stall_pct = int'($urandom % 90);
      send_pkt(1 + int'($urandom % 8), 16 + p);
      repeat ($urandom % 3) @(negedge clk);
    end
    stall_pct = 0;
    repeat (40) @(negedge clk);
    chk("R11", exp_q.size(), 32'd0);

    // credit exhaustion: exactly DEPTH words accepted (R3 R10)
    sink_en = 1'b0;
    out_ready = 1'b0;
    fork send_pkt(8, 99); join_none
    repeat (15) @(negedge clk);
    chk("R3", exp_q.size(), DEPTH);
    chk("R3", {31'd0, in_ready}, 32'd0);
    chk("R3", {28'd0, link_ctl}, 32'd0);
    // one pop: credit back next cycle, in_ready one cycle later (R4 R6)
    out_ready = 1'b1;
    chk("R5", {14'd0, out_first, out_last, out_data}, {14'd0, exp_q.pop_front()});
    @(negedge clk);
    out_ready = 1'b0;
    chk("R6", {28'd0, credit_ret}, 32'd1);
    chk("R4", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    chk("R4", {31'd0, in_ready}, 32'd1);
    sink_en = 1'b1;
    wait fork;
    repeat (20) @(negedge clk);
    chk("R11", exp_q.size(), 32'd0);

    // injected flits into the receiver (R6..R9)
    sink_en = 1'b0;
    out_ready = 1'b1;
    inj = 1'b1;
    put(4'b0010, 16'h0BAD);
    @(negedge clk);
    chk("R7", {31'd0, proto_err}, 32'd1);
    chk("R7", {31'd0, out_valid}, 32'd0);
    chk("R6", {28'd0, credit_ret}, 32'd1);
    inj_ctl = 4'b0011;
    @(negedge clk);
    chk("R8", {31'd0, proto_err}, 32'd0);
    chk("R8", {31'd0, out_valid}, 32'd0);
    inj_ctl = 4'b1101;
    inj_data = 16'hA5A5;
    @(negedge clk);
    chk("R9", {31'd0, proto_err}, 32'd0);
    chk("R9", {14'd0, out_valid, out_first, out_data}, {14'd0, 2'b11, 16'hA5A5});
    chk("R6", {28'd0, credit_ret}, 32'd0);
    inj_ctl = 4'b0000;
    @(negedge clk);
    chk("R9", {31'd0, out_valid}, 32'd0);
    chk("R6", {28'd0, credit_ret}, 32'd1);
    inj_ctl = 4'b0001;
    inj_data = 16'h7777;
    @(negedge clk);
    chk("R7", {31'd0, proto_err}, 32'd1);
    chk("R7", {31'd0, out_valid}, 32'd0);
    inj_ctl = 4'b0010;
    @(negedge clk);
    chk("R8", {31'd0, proto_err}, 32'd0);
    inj_ctl = 4'b0001;
    inj_data = 16'h1111;
    @(negedge clk);
    chk("R8", {14'd0, out_valid, out_first, out_data}, {14'd0, 2'b11, 16'h1111});
    inj_ctl = 4'b0011;
    inj_data = 16'h2222;
    @(negedge clk);
    chk("R5", {14'd0, out_valid, out_last, out_data}, {14'd0, 2'b11, 16'h2222});
    chk("R7", {31'd0, proto_err}, 32'd0);
    inj_ctl = 4'b0000;
    @(negedge clk);
    inj = 1'b0;

    summary();
    $finish;
  end
endmodule